// File: doc/BRIEF.md
# Stream-to-Memory DMA Channel

This channel takes words from a valid/ready stream and stores them into a vector memory at increasing addresses. Software sets a start address and a word count through an APB register block. It then writes a launch register, which places that pair into a small job queue. The transfer engine takes jobs from the queue in order. For each job it writes one memory word per accepted stream beat, and then sets a sticky completion flag. That flag drives an interrupt line when the interrupt is enabled.

The memory side is a request/grant write port that faces a shared arbiter. A request is raised only while a job runs and the stream offers data. A word counts as written in any cycle where request and grant are both high. Stream ready follows the grant, so the channel needs no internal data buffering. APB accesses have no wait states. Read data is captured in the setup phase and held through the access phase.

Register map (word offsets on `paddr[4:2]`): 0 = start address (read/write, `ADDR_W` bits); 1 = word count (read/write, `LEN_W` bits); 2 = launch (write with bit 0 set to queue the current address/count pair, reads 0); 3 = status (read: bit 0 queue empty, bit 1 queue full, bit 2 busy, bit 3 done; writing 1 to bit 3 clears done); 4 = interrupt enable (bit 0).

Top module: `s2m_dma_channel`

## Requirements
- R1: After reset, status reads 0x1 (queue empty, not full, not busy, done clear), `irq` is 0, and neither `st_ready` nor `wr_req` is asserted, even while `st_valid` and `wr_gnt` are high.
- R2: The address register (offset 0x00) reads back the low `ADDR_W` bits written to it. The count register (0x04) reads back the low `LEN_W` bits. The enable register (0x10) reads back bit 0. All other bits read 0.
- R3: A write to 0x08 with bit 0 set queues the current {address, count} pair. Status bit 1 (full) reads 1 once `QDEPTH` jobs are waiting. A launch write made while the queue is full is discarded and never runs.
- R4: Word i of a job (i = 0 .. count-1) is written to address (start + i) mod 2^`ADDR_W`, with `wr_data` equal to the stream data of the i-th accepted beat. A job makes exactly count writes.
- R5: `st_ready` is high only while a job runs and `wr_gnt` is high. `wr_req` is never high while `st_valid` is low. While no job runs, no beat is accepted.
- R6: Queued jobs run one after another in the order they were launched.
- R7: When a job finishes, status bit 3 (done) becomes 1. Writing 1 to status bit 3 clears it, and writing 0 there leaves it unchanged.
- R8: `irq` equals done AND interrupt-enable bit 0.
- R9: A job with count 0 sets done without raising `wr_req`.
- R10: If a job finishes in the same cycle that software writes 1 to clear done, done ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | APB_AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| st_valid | input | 1 | Stream data valid |
| st_ready | output | 1 | Stream data accepted |
| st_data | input | DATA_W | Stream data word |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| wr_gnt | input | 1 | Memory write grant from the arbiter |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Two events can land in the same clock edge: the engine setting the done flag at the end of a job, and a software write-1-to-clear of that flag. The bench holds a one-word job stalled by keeping the grant low. It then raises the grant in the same cycle that it opens the APB setup phase of a clear. As a result, the flag update caused by the final beat and the clear both occur on the following edge. The flag must read 1 afterwards and `irq` must stay high. A separate, later clear must bring both to 0.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int REG_ADDR = 0;
  localparam int REG_LEN  = 1;
  localparam int REG_GO   = 2;
  localparam int REG_STAT = 3;
  localparam int REG_IEN  = 4;

  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_BUSY  = 2;
  localparam int ST_DONE  = 3;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_RUN = 1'b1} eng_state_e;
endpackage

// File: rtl/s2m_desc_fifo.sv
module s2m_desc_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0]   CNT_MAX = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_MAX) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_MAX) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);  // R3
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);  // R6
  AST_FIFO_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);  // R3
endmodule

// File: rtl/s2m_regs.sv
module s2m_regs
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8,
  parameter int APB_AW = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [APB_AW-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  input  logic                    q_empty,
  input  logic                    q_full,
  input  logic                    busy,
  input  logic                    done_pulse,
  output logic                    q_push,
  output logic [ADDR_W+LEN_W-1:0] q_din,
  output logic                    irq
);
  localparam int IDX_W = APB_AW - 2;

  logic [IDX_W-1:0]  idx;
  logic              wr_acc, rd_setup;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              ien_q, done_q;
  logic              unused_bits;

  assign idx         = paddr[APB_AW-1:2];
  assign wr_acc      = psel && penable && pwrite;
  assign rd_setup    = psel && !penable && !pwrite;
  assign unused_bits = ^{paddr[1:0], pwdata};

  assign q_push = wr_acc && (idx == IDX_W'(REG_GO)) && pwdata[0] && !q_full;
  assign q_din  = {addr_q, len_q};
  assign irq    = done_q && ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      len_q  <= '0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
      prdata <= '0;
    end else begin
      if (wr_acc && idx == IDX_W'(REG_ADDR)) addr_q <= pwdata[ADDR_W-1:0];
      if (wr_acc && idx == IDX_W'(REG_LEN))  len_q  <= pwdata[LEN_W-1:0];
      if (wr_acc && idx == IDX_W'(REG_IEN))  ien_q  <= pwdata[0];
      if (done_pulse)
        done_q <= 1'b1;
      else if (wr_acc && idx == IDX_W'(REG_STAT) && pwdata[ST_DONE])
        done_q <= 1'b0;
      if (rd_setup) begin
        prdata <= '0;
        case (idx)
          IDX_W'(REG_ADDR): prdata <= 32'(addr_q);
          IDX_W'(REG_LEN):  prdata <= 32'(len_q);
          IDX_W'(REG_IEN):  prdata <= 32'(ien_q);
          IDX_W'(REG_STAT): begin
            prdata[ST_EMPTY] <= q_empty;
            prdata[ST_FULL]  <= q_full;
            prdata[ST_BUSY]  <= busy;
            prdata[ST_DONE]  <= done_q;
          end
          default: prdata <= '0;
        endcase
      end
    end
  end

  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> done_q);  // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(wr_acc && idx == IDX_W'(REG_STAT))) |=> done_q);  // R7
endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [LEN_W-1:0]  q_len,
  output logic              q_pop,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [DATA_W-1:0] st_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_gnt,
  output logic              done_pulse,
  output logic              running
);
  eng_state_e        state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic              beat;

  assign running  = (state_q == ENG_RUN);
  assign q_pop    = !running && !q_empty;
  assign wr_req   = running && st_valid;
  assign st_ready = running && wr_gnt;
  assign beat     = wr_req && wr_gnt;
  assign wr_addr  = cur_addr_q;
  assign wr_data  = st_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ENG_IDLE;
      cur_addr_q <= '0;
      remain_q   <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (!q_empty) begin
            cur_addr_q <= q_addr;
            remain_q   <= q_len;
            if (q_len == '0) done_pulse <= 1'b1;
            else             state_q    <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          if (beat) begin
            cur_addr_q <= cur_addr_q + 1'b1;
            remain_q   <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) begin
              state_q    <= ENG_IDLE;
              done_pulse <= 1'b1;
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (beat && remain_q != LEN_W'(1)) |=> (cur_addr_q == ADDR_W'($past(cur_addr_q) + 1'b1)));  // R4
  AST_ZERO_LEN_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (q_pop && q_len == '0) |=> !running);  // R9
  AST_RUN_REMAIN: assert property (@(posedge clk) disable iff (rst)
    running |-> (remain_q != '0));  // R9
  AST_NO_REQ_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
    !st_valid |-> !wr_req);  // R5
endmodule

// File: rtl/s2m_dma_channel.sv
module s2m_dma_channel #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16,
  parameter int QDEPTH = 4,
  parameter int APB_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [DATA_W-1:0] st_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_gnt,
  output logic              irq
);
  localparam int DESC_W = ADDR_W + LEN_W;

  logic              q_push, q_pop, q_empty, q_full;
  logic [DESC_W-1:0] q_din, q_dout;
  logic              done_pulse, running, busy;

  assign busy = running || !q_empty;

  s2m_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .APB_AW(APB_AW)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .q_empty(q_empty), .q_full(q_full), .busy(busy), .done_pulse(done_pulse),
    .q_push(q_push), .q_din(q_din), .irq(irq)
  );

  s2m_desc_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  s2m_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .q_empty(q_empty),
    .q_addr(q_dout[DESC_W-1:LEN_W]), .q_len(q_dout[LEN_W-1:0]), .q_pop(q_pop),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt),
    .done_pulse(done_pulse), .running(running)
  );

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done_pulse) || $past(psel && penable && pwrite));  // R8
endmodule

// File: tb/tb_s2m_dma_channel.sv
module tb_s2m_dma_channel;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic st_valid = 0, wr_gnt = 0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, wr_req, irq;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW-1:0] ea [0:63];
  logic [31:0] rd;

  always #10 clk = ~clk;

  s2m_dma_channel dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // Drive n beats with the given stall mode; expected addresses in ea[].
  task automatic run_stream(input int n, input int mode, input logic [DW-1:0] dbase);
    int idx = 0;
    int cyc = 0;
    while (idx < n && cyc < 600) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: begin st_valid = 1; wr_gnt = 1; end
        1: begin st_valid = lfsr[0]; wr_gnt = lfsr[5]; end
        default: begin st_valid = 1; wr_gnt = cyc[0]; end
      endcase
      st_data = dbase + DW'(idx);
      #1;
      if (!wr_gnt && st_ready) chk("R5 ready without grant", 1, 0);
      if (!st_valid && wr_req) chk("R5 request without valid", 1, 0);
      if (wr_req && wr_gnt) begin
        chk("R4 R6 address", 32'(wr_addr), 32'(ea[idx]));
        chk("R4 data", 32'(wr_data), 32'(st_data));
        chk("R5 ready on beat", 32'(st_ready), 1);
        idx++;
      end
      cyc++;
    end
    if (idx < n) chk("R4 beats completed", idx, n);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); st_valid = 1; wr_gnt = 1; #1;
      chk("R4 R5 no extra write", 32'(wr_req), 0);
    end
    @(negedge clk); st_valid = 0; wr_gnt = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    // Reset state
    @(negedge clk); st_valid = 1; wr_gnt = 1; #1;
    chk("R1 st_ready", 32'(st_ready), 0);
    chk("R1 wr_req", 32'(wr_req), 0);
    chk("R1 irq", 32'(irq), 0);
    st_valid = 0; wr_gnt = 0;
    apb_rd(5'h0C, rd); chk("R1 status", rd, 32'h1);

    // Register readback with masking
    apb_wr(5'h00, 32'hFFFF_FFFF); apb_rd(5'h00, rd); chk("R2 addr", rd, 32'h3FF);
    apb_wr(5'h04, 32'hFFFF_FFFF); apb_rd(5'h04, rd); chk("R2 len", rd, 32'hFF);
    apb_wr(5'h10, 32'hFFFF_FFFF); apb_rd(5'h10, rd); chk("R2 ien", rd, 32'h1);
    apb_wr(5'h00, 32'h0000_0155); apb_rd(5'h00, rd); chk("R2 addr pattern", rd, 32'h155);
    apb_rd(5'h08, rd); chk("R2 go reads zero", rd, 0);
    apb_wr(5'h10, 0);

    // Queue fill, overflow drop and in-order execution
    apb_wr(5'h04, 2);
    for (int j = 0; j < 6; j++) begin
      apb_wr(5'h00, 32'h100 + 32'(j) * 32'h10);
      apb_wr(5'h08, 1);
      if (j == 4) begin
        apb_rd(5'h0C, rd); chk("R3 full status", rd & 32'h7, 32'h6);
      end
    end
    apb_rd(5'h0C, rd); chk("R3 still full", rd & 32'h7, 32'h6);
    for (int j = 0; j < 5; j++) begin
      ea[2*j]   = AW'(32'h100 + 32'(j) * 32'h10);
      ea[2*j+1] = AW'(32'h101 + 32'(j) * 32'h10);
    end
    run_stream(10, 1, 16'h5000);
    apb_rd(5'h0C, rd); chk("R3 R6 drained, done", rd, 32'h9);
    apb_wr(5'h0C, 32'h8);

    // Sweep: lengths x start addresses x stall modes
    for (int L = 0; L <= 6; L++) begin
      for (int s = 0; s < 3; s++) begin
        for (int m = 0; m < 3; m++) begin
          logic [AW-1:0] sa;
          logic en;
          sa = (s == 0) ? AW'(0) : (s == 1) ? AW'(10'h2A7) : AW'(10'h3FE);
          en = ((L + s + m) % 2) == 0;
          apb_wr(5'h10, 32'(en));
          apb_wr(5'h00, 32'(sa));
          apb_wr(5'h04, 32'(L));
          apb_wr(5'h08, 1);
          for (int i = 0; i < L; i++) ea[i] = sa + AW'(i);
          run_stream(L, m, DW'(L * 256 + s * 16 + m * 4096));
          apb_rd(5'h0C, rd);
          if (L == 0) chk("R9 zero length done", rd, 32'h9);
          else        chk("R7 done after job", rd, 32'h9);
          chk("R8 irq follows enable", 32'(irq), 32'(en));
          if (L == 1 && s == 0) begin
            apb_wr(5'h0C, 32'h0); apb_rd(5'h0C, rd);
            chk("R7 write 0 keeps done", rd & 32'h8, 32'h8);
          end
          apb_wr(5'h0C, 32'h8);
          apb_rd(5'h0C, rd); chk("R7 cleared", rd, 32'h1);
          chk("R8 irq low after clear", 32'(irq), 0);
        end
      end
    end

    // Completion and clear in the same cycle
    apb_wr(5'h10, 1);
    apb_wr(5'h00, 32'h20);
    apb_wr(5'h04, 1);
    @(negedge clk); st_valid = 1; wr_gnt = 0; st_data = 16'hBEEF;
    apb_wr(5'h08, 1);
    repeat (3) @(negedge clk);
    #1 chk("R5 stalled request", 32'(wr_req), 1);
    chk("R5 stalled ready", 32'(st_ready), 0);
    @(negedge clk);
    wr_gnt = 1; psel = 1; penable = 0; pwrite = 1; paddr = 5'h0C; pwdata = 32'h8;
    #1 chk("R4 collision beat address", 32'(wr_addr), 32'h20);
    @(negedge clk); wr_gnt = 0; st_valid = 0; penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    apb_rd(5'h0C, rd); chk("R10 set wins over clear", rd & 32'h8, 32'h8);
    chk("R10 R8 irq kept", 32'(irq), 1);
    apb_wr(5'h0C, 32'h8);
    apb_rd(5'h0C, rd); chk("R7 later clear", rd & 32'h8, 0);
    chk("R8 irq dropped", 32'(irq), 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule